// File: doc/BRIEF.md
# Parallel-Jam Serial-Out Shift Register

This block is an eight-stage shift register with two ways of filling it. In serial mode the register shifts on each rising clock edge. A new bit enters at the head, and the bit in the last stage leaves at the far end. In jam mode every stage is forced straight to its bit of a parallel word. The force acts at once and needs no clock edge. Each stage keeps following its parallel bit for as long as the mode input stays high.

Only the three stages at the far end are visible from outside. The usual use is to capture a word with a short jam pulse and then clock it out one bit at a time from the last stage, most significant bit first. Wider registers are built by chaining instances: the last-stage output of one instance drives the serial input of the next. The contents after power-up are undefined. They become defined after the first jam or after a full register's worth of serial shifts.

Top module: `plso_shift_reg`

## Requirements
- R1: The register has eight stages, numbered 1 to 8, and stage 1 takes the serial input. Output bit `tap_q[i]` presents stage 6+i, so `tap_q[0]` is stage 6, `tap_q[1]` is stage 7 and `tap_q[2]` is stage 8. A bit shifted in therefore reaches `tap_q[0]` on the 6th rising edge and `tap_q[2]` on the 8th.
- R2: While `jam_en` is 0, each rising edge of `clk` loads `ser_in` into stage 1 and moves stage n-1 into stage n for n = 2 to 8.
- R3: While `jam_en` is 1, stage k equals `par_in[k-1]`. This happens without any clock edge, and each stage follows changes of `par_in` for as long as `jam_en` stays 1.
- R4: While `jam_en` is 1, rising clock edges and changes of `ser_in` have no effect on the stages.
- R5: While `jam_en` is 0, a falling clock edge or a steady clock leaves every stage unchanged.
- R6: When `jam_en` returns to 0, the jammed values are held until the next rising edge, and that edge shifts them.
- R7: After a jam of word P followed by release, `tap_q[2]` presents P[7], then P[6], and so on down to P[0] on successive rising edges.
- R8: Connecting `tap_q[2]` of one instance to `ser_in` of a second instance gives a sixteen-stage serial chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the rising edge is the active edge |
| ser_in | input | 1 | Serial data into stage 1 |
| jam_en | input | 1 | 1 = asynchronous parallel jam, 0 = serial shift |
| par_in | input | 8 | Parallel data; bit k-1 goes to stage k |
| tap_q | output | 3 | Contents of stages 6, 7 and 8 (bit 0 = stage 6) |

## Verification
The bench builds the block with its default parameters: eight stages, with outputs from stage 6 upwards. It uses two instances, and the second is fed from the last stage of the first. With the two instances chained, the bench can see all eight stages of the first instance as they move through the outputs of the second. That means no internal probes are needed, and the cascade arrangement is exercised at the same time. Jam pulses are placed in the middle of clock cycles, including pulses that begin and end between two edges. This brings the asynchronous path and the hold after release within reach.

// File: rtl/plso_pkg.sv
package plso_pkg;

  // Per-stage asynchronous control pair derived from the jam request.
  typedef struct packed {
    logic set;
    logic clr;
  } jam_ctl_t;

  // Force request for one stage: set when jamming a one, clear when jamming a zero.
  function automatic jam_ctl_t jam_decode(input logic jam, input logic bit_v);
    jam_ctl_t c;
    c.set = jam & bit_v;
    c.clr = jam & ~bit_v;
    return c;
  endfunction

  // D input of stage idx (0-based): serial input for the head, neighbour otherwise.
  function automatic logic stage_d(input int idx, input logic ser, input logic prev_q);
    return (idx == 0) ? ser : prev_q;
  endfunction

endpackage

// File: rtl/plso_stage.sv
module plso_stage (
  input  logic clk,
  input  logic d,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // Rising-edge flop with asynchronous clear and preset; clear wins.
  always_ff @(posedge clk or posedge set_i or posedge clr_i) begin
    if (clr_i)      q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else            q <= d;
  end
endmodule

// File: rtl/plso_jam_decode.sv
module plso_jam_decode #(
  parameter int STAGES = 8
) (
  input  logic              jam_en,
  input  logic [STAGES-1:0] par_in,
  output logic [STAGES-1:0] set_v,
  output logic [STAGES-1:0] clr_v
);
  import plso_pkg::*;

  for (genvar k = 0; k < STAGES; k++) begin : g_bit
    jam_ctl_t ctl;
    always_comb begin
      ctl      = jam_decode(jam_en, par_in[k]);
      set_v[k] = ctl.set;
      clr_v[k] = ctl.clr;
    end
  end
endmodule

// File: rtl/plso_chain.sv
module plso_chain #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              ser_in,
  input  logic [STAGES-1:0] set_v,
  input  logic [STAGES-1:0] clr_v,
  output logic [STAGES-1:0] stage_q
);
  import plso_pkg::*;

  logic [STAGES-1:0] d_v;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_comb d_v[k] = stage_d(k, ser_in, 1'b0);
    end else begin : g_body
      always_comb d_v[k] = stage_d(k, ser_in, stage_q[k-1]);
    end

    plso_stage u_stage (
      .clk  (clk),
      .d    (d_v[k]),
      .set_i(set_v[k]),
      .clr_i(clr_v[k]),
      .q    (stage_q[k])
    );
  end
endmodule

// File: rtl/plso_shift_reg.sv
module plso_shift_reg #(
  parameter int STAGES = 8,
  parameter int TAP_LO = 6,
  localparam int TAPS  = STAGES - TAP_LO + 1
) (
  input  logic              clk,
  input  logic              ser_in,
  input  logic              jam_en,
  input  logic [STAGES-1:0] par_in,
  output logic [TAPS-1:0]   tap_q
);
  logic [STAGES-1:0] set_v;
  logic [STAGES-1:0] clr_v;
  logic [STAGES-1:0] stage_q;

  plso_jam_decode #(.STAGES(STAGES)) u_decode (
    .jam_en(jam_en),
    .par_in(par_in),
    .set_v (set_v),
    .clr_v (clr_v)
  );

  plso_chain #(.STAGES(STAGES)) u_chain (
    .clk    (clk),
    .ser_in (ser_in),
    .set_v  (set_v),
    .clr_v  (clr_v),
    .stage_q(stage_q)
  );

  // Only the far-end stages are brought out.
  assign tap_q = stage_q[STAGES-1:TAP_LO-1];
endmodule

// File: rtl/plso_shift_reg_chk.sv
module plso_shift_reg_chk #(
  parameter int STAGES = 8,
  parameter int TAPS   = 3
) (
  input logic              clk,
  input logic              ser_in,
  input logic              jam_en,
  input logic [STAGES-1:0] par_in,
  input logic [TAPS-1:0]   tap_q
);
  // Set by any jam since the last rising edge (or a jam held across it).
  logic            jam_recent = 1'b0;
  // Becomes 1 one edge after the first jam; contents are defined from then on.
  logic            primed     = 1'b0;
  logic [TAPS-1:0] neg_snap   = '0;

  always_ff @(posedge clk or posedge jam_en) begin
    if (jam_en) jam_recent <= 1'b1;
    else        jam_recent <= 1'b0;
  end

  always_ff @(posedge clk) primed <= primed | jam_recent;

  always_ff @(negedge clk) neg_snap <= tap_q;

  // R2: a jam-free cycle moves every visible stage one place toward the end.
  a_r2_shift_step: assert property (@(posedge clk) disable iff (!primed)
    (!jam_recent && !jam_en) |-> (tap_q[TAPS-1:1] == $past(tap_q[TAPS-2:0])));

  // R3: while jamming, the visible stages equal the top parallel bits.
  a_r3_jam_follow: assert property (@(posedge clk)
    jam_en |-> (tap_q == par_in[STAGES-1:STAGES-TAPS]));

  // R4: clock edges during a steady jam change nothing.
  a_r4_clock_ignored: assert property (@(posedge clk) disable iff (!primed)
    (jam_en && $past(jam_en) && $stable(par_in)) |-> $stable(tap_q));

  // R5: between the falling edge and the next rising edge nothing moves.
  a_r5_fall_holds: assert property (@(posedge clk) disable iff (!primed)
    !jam_recent |-> (tap_q == neg_snap));

  wire unused_ser = ser_in;
endmodule

bind plso_shift_reg plso_shift_reg_chk #(.STAGES(STAGES), .TAPS(TAPS)) u_chk (
  .clk   (clk),
  .ser_in(ser_in),
  .jam_en(jam_en),
  .par_in(par_in),
  .tap_q (tap_q)
);

// File: tb/plso_shift_reg_tb_top.sv
module plso_shift_reg_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       ser_in = 1'b0;
  logic       jam_en = 1'b0;
  logic [7:0] par_in = '0;
  logic       tail_jam = 1'b0;
  logic [7:0] tail_par = '0;
  logic [2:0] tap_q;
  logic [2:0] tail_q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural model of both chained registers: entry 0 = head stage 1.
  bit ref_q[$];

  always #(CLK_P/2) clk = ~clk;

  plso_shift_reg dut_i (
    .clk(clk), .ser_in(ser_in), .jam_en(jam_en), .par_in(par_in), .tap_q(tap_q)
  );

  plso_shift_reg tail_i (
    .clk(clk), .ser_in(tap_q[2]), .jam_en(tail_jam), .par_in(tail_par), .tap_q(tail_q)
  );

  function automatic logic [2:0] ref_taps(input int base);
    return {ref_q[base+7], ref_q[base+6], ref_q[base+5]};
  endfunction

  function automatic void ref_load(input int base, input logic [7:0] w);
    for (int k = 0; k < 8; k++) ref_q[base+k] = w[k];
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_both(input string req);
    chk(req, tap_q, ref_taps(0));
    chk({req, " tail"}, tail_q, ref_taps(8));
  endtask

  // Entered at negedge+1; leaves at the following negedge+1.
  task automatic shift(input logic b);
    ser_in = b;
    @(posedge clk);
    #2;
    ref_q.push_front(b);
    void'(ref_q.pop_back());
    chk_both("R2");
    @(negedge clk);
    #1;
    chk_both("R5");
  endtask

  initial begin
    logic [7:0] word;
    for (int k = 0; k < 16; k++) ref_q.push_back(1'b0);

    // Jam both registers in mid-cycle (first rising edge is at t=5).
    #2;
    jam_en = 1'b1; par_in = 8'hA5;
    tail_jam = 1'b1; tail_par = 8'h3C;
    #1;
    ref_load(0, 8'hA5); ref_load(8, 8'h3C);
    chk("R3 jam without clock", tap_q, 3'b101);
    chk_both("R3");

    // Follow a parallel change while held.
    par_in = 8'h5A;
    #1;
    ref_load(0, 8'h5A);
    chk("R3 follow", tap_q, 3'b010);

    // Clock and serial input ignored while jamming.
    for (int i = 0; i < 3; i++) begin
      ser_in = ~ser_in;
      @(posedge clk);
      #2;
      chk("R4", tap_q, 3'b010);
    end

    // Release mid-cycle; values hold until the next rising edge.
    word = 8'b1001_0110;
    par_in = word;
    #1;
    ref_load(0, word);
    tail_jam = 1'b0;
    jam_en = 1'b0;
    #1;
    chk("R6 hold after release", tap_q, 3'b100);
    @(negedge clk);
    #1;
    chk("R6 hold across fall", tap_q, 3'b100);

    // Unload: stage 8 walks the jammed bits from 7 down to 0.
    for (int i = 0; i < 8; i++) begin
      chk("R7 unload order", {2'b00, tap_q[2]}, {2'b00, word[7-i]});
      shift(1'b0);
    end

    // Single marker: reaches stage 6 after 6 edges and stage 8 after 8.
    shift(1'b1);
    for (int i = 2; i <= 8; i++) begin
      shift(1'b0);
      if (i == 6) chk("R1 stage 6", tap_q, 3'b001);
      if (i == 7) chk("R1 stage 7", tap_q, 3'b010);
      if (i == 8) chk("R1 stage 8", tap_q, 3'b100);
    end

    // Serial pattern through both instances.
    for (int i = 0; i < 24; i++) shift(((i * 7) % 5) < 2);
    chk("R8 cascade", tail_q, ref_taps(8));

    // Jam pulse that starts and ends between two rising edges.
    jam_en = 1'b1; par_in = 8'hC3;
    #1;
    ref_load(0, 8'hC3);
    chk("R3 short pulse", tap_q, 3'b110);
    jam_en = 1'b0;
    #1;
    chk("R6 short pulse hold", tap_q, 3'b110);
    for (int i = 0; i < 10; i++) shift(i[0]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule